// File: doc/BRIEF.md
# Host Memory Access Port with Split-Word Mode

This block is the host-side port of a 1024-word by 24-bit result memory. A processor uses it to preload the array before a processing run and to read the results back afterwards. Read and write strobes are active low and are not tied to the system clock, so the block passes them through a synchronizer and performs exactly one memory access for each falling edge it detects. The address, the write data and the upper-word-select pin are taken at that moment.

Two host modes exist. In the full-width mode the bus carries a whole 24-bit word. In the narrow mode the bus carries a word in two parts: the low 16 bits travel on bus bits 15:0, and the top 8 bits travel on bus bits 7:0. The upper-word-select pin picks which part a transfer carries. A narrow write changes only its own lane of the stored word.

In every other mode code the processing datapath owns the array. The port then streams the processed data to the bus, with the read strobe acting only as an output enable. A synchronous active-low clear input wipes the whole array and the read register on every clock while it is held low.

Top module: `hostmem_port`

## Requirements
- R1: After `rst_ni` is released, the read register holds zero. With `rd_ni` high, `dio_oe_o` is 0, and in a host mode `dio_o` reads 0.
- R2: The host modes are mode codes 3'b110 (full width) and 3'b111 (narrow). In full-width mode, a falling edge on `wr_ni` stores all 24 bits of `dio_i` at `addr_i`. A falling edge on `rd_ni` loads the word at `addr_i`, and that word appears on `dio_o`. The access takes place on the third rising clock edge after the strobe is first seen low.
- R3: A narrow write with `uws_i`=0 writes `dio_i[15:0]` into bits 15:0 of the addressed word. Bits 23:16 of that word and bus bits 23:16 are left alone.
- R4: A narrow write with `uws_i`=1 writes `dio_i[7:0]` into bits 23:16 of the addressed word. Bits 15:0 of that word are left alone.
- R5: A narrow read drives word bits 23:16 on `dio_o[7:0]` when `uws_i`=1, and word bits 15:0 on `dio_o[15:0]` when `uws_i`=0. All remaining bus bits read zero.
- R6: In full-width mode, `uws_i` has no effect on reads or writes.
- R7: In every other mode code, `dio_o` equals `stream_data_i`. Write strobes, the address and `uws_i` change nothing in the memory.
- R8: `dio_oe_o` is 1 exactly while `rd_ni` is low, in every mode.
- R9: While `clr_ni` is low, every word and the read register are set to zero on each clock, and no host write takes effect.
- R10: A strobe held low causes only one access. Changing the address or the data while the strobe stays low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low array clear, sampled on the clock |
| mode_i | input | 3 | Mode code; 3'b110 full-width host mode, 3'b111 narrow host mode |
| wr_ni | input | 1 | Active-low host write strobe, asynchronous |
| rd_ni | input | 1 | Active-low host read strobe and output enable |
| uws_i | input | 1 | Upper-word select for narrow mode |
| addr_i | input | 10 | Host word address |
| dio_i | input | 24 | Host bus data into the port |
| stream_data_i | input | 24 | Processed data from the datapath, streamed out in the other modes |
| dio_o | output | 24 | Bus data out of the port |
| dio_oe_o | output | 1 | Bus drive enable |

## Verification
The same address is written first with a full word, then with a lower-lane write and then with an upper-lane write. A full-width read after each step shows whether a narrow write spilled into the other lane. The narrow writes carry non-zero data on the bus bits that must be ignored, which catches a wrong bus slice. Narrow reads of both halves, compared with full reads of the same word, tell the two read formats apart, and `uws_i` is toggled in full-width mode to show it changes nothing there. Writes issued in a processing mode, during a clear, or after an address change under a held strobe are each followed by host reads. These reads separate a dropped access from a misdirected one.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_HOST_FULL   = 3'b110;
  localparam logic [MODE_W-1:0] MODE_HOST_NARROW = 3'b111;

  function automatic logic mode_is_host(input logic [MODE_W-1:0] m);
    return (m == MODE_HOST_FULL) || (m == MODE_HOST_NARROW);
  endfunction
endpackage

// File: rtl/hmp_strobe_sync.sv
module hmp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  // chain[STAGES-1] is the synchronized strobe, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], strobe_ni};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

  // one access per strobe edge
  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/hmp_lane_mem.sv
module hmp_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (!clr_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (we_lo_i) mem_q[waddr_i][LO_W-1:0]      <= wdata_i[LO_W-1:0];
      if (we_hi_i) mem_q[waddr_i][DATA_W-1:LO_W] <= wdata_i[DATA_W-1:LO_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (!clr_ni) rdata_q <= '0;
    else if (re_i)    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  assert_clear_zeroes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (rdata_o == '0));
  assert_no_write_in_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i || we_hi_i) |-> clr_ni);
endmodule

// File: rtl/hmp_bus_fmt.sv
module hmp_bus_fmt #(
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic              narrow_i,
  input  logic              uws_i,
  input  logic              do_write_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_lo_o,
  output logic              we_hi_o,
  output logic [DATA_W-1:0] rbus_o
);
  localparam int HI_W = DATA_W - LO_W;

  always_comb begin
    if (narrow_i) begin
      // upper lane travels on the low bus bits
      wdata_o = {bus_i[HI_W-1:0], bus_i[LO_W-1:0]};
      we_lo_o = do_write_i & ~uws_i;
      we_hi_o = do_write_i &  uws_i;
      rbus_o  = uws_i ? {{LO_W{1'b0}}, word_i[DATA_W-1:LO_W]}
                      : {{HI_W{1'b0}}, word_i[LO_W-1:0]};
    end else begin
      wdata_o = bus_i;
      we_lo_o = do_write_i;
      we_hi_o = do_write_i;
      rbus_o  = word_i;
    end
  end

  always_comb begin
    assert_narrow_one_lane_R3: assert (!(narrow_i && we_lo_o && we_hi_o));
  end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 24,
  parameter int LO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              uws_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dio_i,
  input  logic [DATA_W-1:0] stream_data_i,
  output logic [DATA_W-1:0] dio_o,
  output logic              dio_oe_o
);
  logic              host_mode, narrow_mode;
  logic              wr_fall, rd_fall;
  logic              do_write, do_read;
  logic              we_lo, we_hi;
  logic [DATA_W-1:0] wdata, rword, rbus;

  assign host_mode   = mode_is_host(mode_i);
  assign narrow_mode = (mode_i == MODE_HOST_NARROW);

  hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_ni(wr_ni), .fall_o(wr_fall));
  hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_ni(rd_ni), .fall_o(rd_fall));

  assign do_write = wr_fall & host_mode & clr_ni;
  assign do_read  = rd_fall & host_mode;

  hmp_bus_fmt #(.DATA_W(DATA_W), .LO_W(LO_W)) u_fmt (
    .narrow_i(narrow_mode), .uws_i(uws_i), .do_write_i(do_write),
    .bus_i(dio_i), .word_i(rword),
    .wdata_o(wdata), .we_lo_o(we_lo), .we_hi_o(we_hi), .rbus_o(rbus));

  hmp_lane_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni),
    .we_lo_i(we_lo), .we_hi_i(we_hi), .waddr_i(addr_i), .wdata_i(wdata),
    .re_i(do_read), .raddr_i(addr_i), .rdata_o(rword));

  assign dio_o    = host_mode ? rbus : stream_data_i;
  assign dio_oe_o = ~rd_ni;

  assert_proc_mode_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_mode |-> !(we_lo || we_hi));
  assert_narrow_high_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_mode |-> (dio_o[DATA_W-1:LO_W] == '0));
  assert_full_both_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOST_FULL) |-> (we_lo == we_hi));
endmodule

// File: tb/sim_hostmem_port.sv
`timescale 1ns/1ps
module sim_hostmem_port;
  logic        clk = 0, rst_ni = 0, clr_ni = 1;
  logic [2:0]  mode = 3'b110;
  logic        wr_ni = 1, rd_ni = 1, uws = 0;
  logic [9:0]  addr = '0;
  logic [23:0] dio_i = '0, stream = '0, dio_o;
  logic        dio_oe;
  int          n_chk = 0, n_fail = 0;
  logic [23:0] got;

  always #4 clk = ~clk;

  hostmem_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(clr_ni), .mode_i(mode),
    .wr_ni(wr_ni), .rd_ni(rd_ni), .uws_i(uws), .addr_i(addr),
    .dio_i(dio_i), .stream_data_i(stream), .dio_o(dio_o), .dio_oe_o(dio_oe));

  typedef struct packed {
    logic [2:0]  mode;
    logic        wr;
    logic        uws;
    logic [9:0]  addr;
    logic [23:0] data;
    logic [3:0]  req;
  } vec_t;

  // reads carry the expected word in data
  localparam vec_t VECS [11] = '{
    '{3'b110, 1'b1, 1'b0, 10'd5,   24'hA1B2C3, 4'd2},  // R2 full write
    '{3'b110, 1'b0, 1'b0, 10'd5,   24'hA1B2C3, 4'd2},  // R2 full read
    '{3'b111, 1'b1, 1'b0, 10'd5,   24'hFF1234, 4'd3},  // R3 lower lane, bus 23:16 junk
    '{3'b110, 1'b0, 1'b0, 10'd5,   24'hA11234, 4'd3},
    '{3'b111, 1'b1, 1'b1, 10'd5,   24'hFFFF5E, 4'd4},  // R4 upper lane from bus 7:0
    '{3'b110, 1'b0, 1'b0, 10'd5,   24'h5E1234, 4'd4},
    '{3'b111, 1'b0, 1'b1, 10'd5,   24'h00005E, 4'd5},  // R5 upper half read
    '{3'b111, 1'b0, 1'b0, 10'd5,   24'h001234, 4'd5},  // R5 lower half read
    '{3'b110, 1'b1, 1'b1, 10'd1023, 24'h123456, 4'd6}, // R6 uws ignored
    '{3'b110, 1'b0, 1'b1, 10'd1023, 24'h123456, 4'd6},
    '{3'b110, 1'b0, 1'b0, 10'd0,   24'h000000, 4'd9}   // R9 cleared word
  };

  task automatic check(input int req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] m, input logic u, input logic [9:0] a, input logic [23:0] d);
    @(negedge clk);
    mode = m; uws = u; addr = a; dio_i = d; wr_ni = 0;
    cyc(5);
    wr_ni = 1;
    cyc(4);
  endtask

  task automatic host_rd(input logic [2:0] m, input logic u, input logic [9:0] a, output logic [23:0] d);
    @(negedge clk);
    mode = m; uws = u; addr = a; rd_ni = 0;
    cyc(5);
    d = dio_o;
    rd_ni = 1;
    cyc(4);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_ni = 0;
    cyc(2); clr_ni = 1;
    cyc(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    cyc(50000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    check(1, {23'd0, dio_oe}, 24'd0);
    check(1, dio_o, 24'd0);
    rst_ni = 1;
    cyc(2);
    check(1, {23'd0, dio_oe}, 24'd0);
    check(1, dio_o, 24'd0);
    do_clear();

    foreach (VECS[i]) begin
      if (VECS[i].wr) host_wr(VECS[i].mode, VECS[i].uws, VECS[i].addr, VECS[i].data);
      else begin
        host_rd(VECS[i].mode, VECS[i].uws, VECS[i].addr, got);
        check(int'(VECS[i].req), got, VECS[i].data);
      end
    end

    // R8 enable follows read strobe
    @(negedge clk); mode = 3'b110; rd_ni = 0;
    #1 check(8, {23'd0, dio_oe}, 24'd1);
    rd_ni = 1;
    #1 check(8, {23'd0, dio_oe}, 24'd0);

    // R7 processing mode streams data, writes dropped
    @(negedge clk); mode = 3'b010; stream = 24'hC0FFEE; rd_ni = 0;
    cyc(1);
    check(7, dio_o, 24'hC0FFEE);
    check(8, {23'd0, dio_oe}, 24'd1);
    rd_ni = 1;
    cyc(1);
    check(8, {23'd0, dio_oe}, 24'd0);
    host_wr(3'b000, 1'b0, 10'd7, 24'h777777);
    host_wr(3'b101, 1'b1, 10'd5, 24'h999999);
    host_rd(3'b110, 1'b0, 10'd7, got);
    check(7, got, 24'h000000);
    host_rd(3'b110, 1'b0, 10'd5, got);
    check(7, got, 24'h5E1234);

    // R9 clear wipes stored words and the read register
    host_rd(3'b110, 1'b0, 10'd5, got);
    do_clear();
    check(9, dio_o, 24'h000000);
    host_rd(3'b110, 1'b0, 10'd5, got);
    check(9, got, 24'h000000);
    // R9 write during clear dropped
    @(negedge clk); clr_ni = 0;
    host_wr(3'b110, 1'b0, 10'd20, 24'h111111);
    clr_ni = 1;
    host_rd(3'b110, 1'b0, 10'd20, got);
    check(9, got, 24'h000000);

    // R10 held strobe: later address/data changes ignored
    @(negedge clk); mode = 3'b110; addr = 10'd10; dio_i = 24'h0ABCDE; wr_ni = 0;
    cyc(5);
    addr = 10'd11; dio_i = 24'hFFFFFF;
    cyc(5);
    wr_ni = 1;
    cyc(4);
    host_rd(3'b110, 1'b0, 10'd10, got);
    check(10, got, 24'h0ABCDE);
    host_rd(3'b110, 1'b0, 10'd11, got);
    check(10, got, 24'h000000);

    // R2 second full pattern, R6 uws toggled on read
    host_wr(3'b110, 1'b0, 10'd512, 24'h800001);
    host_rd(3'b110, 1'b1, 10'd512, got);
    check(6, got, 24'h800001);

    finish_run();
  end
endmodule